// File: doc/BRIEF.md
# Address Decoder with Boot Remap

This block sorts every processor access in a 4 GB byte address space into one of three targets: on-chip SRAM in the bottom 4 MB, on-chip peripherals in the top 4 MB, or the external bus window between them. For an external access it also names the chip select that serves it. It raises an abort when an external address has no owner. Eight 1 MB external banks each have a programmable base and an enable bit. When two enabled banks share a base, the lower chip-select index wins.

The map starts in a boot state. In that state the bottom 4 MB is routed to the boot device on chip select 0, so the reset vector at address zero is fetched from non-volatile memory. Chip selects 1 to 7 cannot be reached. When software sets the remap bit, SRAM moves to address zero and the other chip selects open up. From then on, software can rewrite the exception vectors (0x00 to 0x20). Only a reset clears the remap state.

Peripheral registers can only be read or written as whole words. For a byte or half-word access to that region, the block clears the low two address bits and reports a word-sized access.

Top module: `addr_remap_dec`

## Requirements
- R1: After remap, a valid access with address bits [31:22] all zero gives region code 1 (SRAM), chip select 0, no abort, and the address passed through unchanged.
- R2: Before remap, a valid access with address bits [31:22] all zero gives region code 2 (external) on chip select 0 with no abort, whether or not bank 0 is enabled.
- R3: A clock edge with `remap_wr` high and `remap_wbit` high sets the remap state. A write with `remap_wbit` low has no effect. Once set, the state stays set until reset.
- R4: A valid access with address bits [31:22] all ones gives region code 3 (peripheral) and never aborts. `dec_addr` equals the input address with bits [1:0] cleared, and `dec_size` is 2 (word).
- R5: A valid external-window access whose bits [31:20] equal the base of an enabled, eligible bank gives region code 2 with that bank's index. If several banks match, the lowest index is chosen.
- R6: Before remap, only bank 0 is eligible, so a hit on banks 1 to 7 counts as no hit. An external-window access with no eligible hit raises `dec_abort`, with region code 0 and chip select 0.
- R7: A bank whose enable bit is 0 never matches, whatever its base.
- R8: Outside the peripheral region, `dec_addr` and `dec_size` (0 byte, 1 half-word, 2 word) equal the inputs.
- R9: With `acc_valid` low, the region code is 0 and `dec_abort` is low.
- R10: Reset clears the remap state and disables all eight banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, pin or internal |
| remap_wr | input | 1 | Write strobe for the remap command |
| remap_wbit | input | 1 | Command bit; only a one has an effect |
| bank_wr | input | 1 | Write strobe for a bank setting |
| bank_idx | input | 3 | Chip select being configured |
| bank_base | input | 12 | Bank base, compared with address bits [31:20] |
| bank_en | input | 1 | Enable bit for the bank |
| acc_valid | input | 1 | Access present |
| acc_addr | input | 32 | Byte address |
| acc_size | input | 2 | 0 byte, 1 half-word, 2 word |
| dec_region | output | 2 | 0 none, 1 SRAM, 2 external, 3 peripheral |
| dec_cs | output | 3 | Selected chip select |
| dec_abort | output | 1 | Undefined external address |
| dec_addr | output | 32 | Address after alignment |
| dec_size | output | 2 | Size after alignment |
| remapped | output | 1 | Remap state |

## Verification
The bench probes the window edges at 0x003F_FFFF/0x0040_0000 and 0xFFBF_FFFF/0xFFC0_0000. A design with an off-by-one edge would put a boundary access in the wrong region or abort it. The bench sets two banks to the same base, which catches a priority encoder that picks the highest index. It also hits bank 1 before remap, which a design without the chip-select gate would grant. A zero write to the remap bit, and a reset after remap, expose a latch that is not write-one-only or that does not clear. Unaligned byte and half-word peripheral accesses expose alignment that drops the size override or clears the wrong bits.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int unsigned PA_W = 32;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_SRAM = 2'd1,
    RGN_EXT  = 2'd2,
    RGN_PERI = 2'd3
  } region_e;

  localparam logic [1:0] SZ_WORD = 2'd2;

  // Clears the byte-lane bits so a narrow access becomes a word access.
  function automatic logic [PA_W-1:0] word_align(input logic [PA_W-1:0] a);
    return {a[PA_W-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/remap_latch.sv
module remap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic set_evt,
  output logic remapped
);
  assign set_evt = wr & wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remapped <= 1'b0;
    else if (set_evt) remapped <= 1'b1;
  end
endmodule

// File: rtl/region_classify.sv
module region_classify #(
  parameter int WIN_BITS = 22,
  localparam int HI_W = 32 - WIN_BITS
) (
  input  logic [HI_W-1:0] addr_hi,
  output logic            is_low,
  output logic            is_per,
  output logic            is_ext
);
  assign is_low = (addr_hi == '0);
  assign is_per = (addr_hi == '1);
  assign is_ext = ~is_low & ~is_per;
endmodule

// File: rtl/bank_table.sv
module bank_table #(
  parameter int N_CS = 8,
  parameter int BANK_BITS = 20,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1,
  localparam int BASE_W = 32 - BANK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CS_W-1:0]   cfg_idx,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic              cfg_en,
  input  logic [BASE_W-1:0] look_hi,
  input  logic              allow_all,
  output logic              hit,
  output logic [CS_W-1:0]   hit_idx
);
  logic [N_CS-1:0] match;

  for (genvar i = 0; i < N_CS; i++) begin : g_bank
    logic [BASE_W-1:0] base_q;
    logic              en_q;
    logic              eligible;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        en_q   <= 1'b0;
      end else if (cfg_wr && (cfg_idx == CS_W'(i))) begin
        base_q <= cfg_base;
        en_q   <= cfg_en;
      end
    end

    if (i == 0) begin : g_boot
      assign eligible = 1'b1;
    end else begin : g_gated
      assign eligible = allow_all;
    end

    assign match[i] = en_q & eligible & (look_hi == base_q);
  end

  // Lowest index wins: walk down so the last assignment is the smallest hit.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = CS_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_remap_dec.sv
module addr_remap_dec
  import addr_dec_pkg::*;
#(
  parameter int N_CS = 8,
  parameter int BANK_BITS = 20,
  parameter int WIN_BITS = 22,
  localparam int CS_W = (N_CS > 1) ? $clog2(N_CS) : 1,
  localparam int BASE_W = 32 - BANK_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              remap_wr,
  input  logic              remap_wbit,
  input  logic              bank_wr,
  input  logic [CS_W-1:0]   bank_idx,
  input  logic [BASE_W-1:0] bank_base,
  input  logic              bank_en,
  input  logic              acc_valid,
  input  logic [31:0]       acc_addr,
  input  logic [1:0]        acc_size,
  output logic [1:0]        dec_region,
  output logic [CS_W-1:0]   dec_cs,
  output logic              dec_abort,
  output logic [31:0]       dec_addr,
  output logic [1:0]        dec_size,
  output logic              remapped
);
  logic            remap_set_evt;
  logic            is_low, is_per, is_ext;
  logic            bank_hit;
  logic [CS_W-1:0] bank_hit_idx;
  region_e         rgn;

  remap_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr(remap_wr), .wbit(remap_wbit),
    .set_evt(remap_set_evt), .remapped(remapped)
  );

  region_classify #(.WIN_BITS(WIN_BITS)) u_cls (
    .addr_hi(acc_addr[31:WIN_BITS]),
    .is_low(is_low), .is_per(is_per), .is_ext(is_ext)
  );

  bank_table #(.N_CS(N_CS), .BANK_BITS(BANK_BITS)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(bank_wr), .cfg_idx(bank_idx), .cfg_base(bank_base), .cfg_en(bank_en),
    .look_hi(acc_addr[31:BANK_BITS]), .allow_all(remapped),
    .hit(bank_hit), .hit_idx(bank_hit_idx)
  );

  always_comb begin
    rgn       = RGN_NONE;
    dec_cs    = '0;
    dec_abort = 1'b0;
    dec_addr  = acc_addr;
    dec_size  = acc_size;
    if (acc_valid) begin
      if (is_per) begin
        rgn      = RGN_PERI;
        dec_addr = word_align(acc_addr);
        dec_size = SZ_WORD;
      end else if (is_low) begin
        rgn = remapped ? RGN_SRAM : RGN_EXT;
      end else if (is_ext && bank_hit) begin
        rgn    = RGN_EXT;
        dec_cs = bank_hit_idx;
      end else begin
        dec_abort = 1'b1;
      end
    end
  end

  assign dec_region = rgn;
endmodule

// File: rtl/addr_remap_dec_chk.sv
module addr_remap_dec_chk #(
  parameter int CS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [1:0]      dec_region,
  input logic [CS_W-1:0] dec_cs,
  input logic            dec_abort,
  input logic [1:0]      dec_addr_lo,
  input logic [1:0]      dec_size,
  input logic            remapped,
  input logic            remap_set_evt,
  input logic            is_low,
  input logic            is_per
);
  // R3
  remap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remapped |=> remapped);
  // R3
  remap_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_set_evt |=> remapped);
  // R3
  remap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && !remap_set_evt) |=> !remapped);
  // R1
  sram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_low && remapped) |-> (dec_region == 2'd1 && !dec_abort));
  // R2
  boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_low && !remapped) |-> (dec_region == 2'd2 && dec_cs == '0 && !dec_abort));
  // R4
  periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && is_per) |-> (dec_region == 2'd3 && !dec_abort && dec_addr_lo == 2'b00 && dec_size == 2'd2));
  // R6
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!remapped && dec_region == 2'd2) |-> (dec_cs == '0));
  // R6
  abort_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_abort |-> (dec_region == 2'd0 && dec_cs == '0));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (dec_region == 2'd0 && !dec_abort));
endmodule

bind addr_remap_dec addr_remap_dec_chk #(.CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
  .dec_region(dec_region), .dec_cs(dec_cs), .dec_abort(dec_abort),
  .dec_addr_lo(dec_addr[1:0]), .dec_size(dec_size), .remapped(remapped),
  .remap_set_evt(remap_set_evt), .is_low(is_low), .is_per(is_per)
);

// File: tb/addr_remap_dec_bench.sv
module addr_remap_dec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        remap_wr = 1'b0, remap_wbit = 1'b0;
  logic        bank_wr = 1'b0;
  logic [2:0]  bank_idx = '0;
  logic [11:0] bank_base = '0;
  logic        bank_en = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [1:0]  dec_region;
  logic [2:0]  dec_cs;
  logic        dec_abort;
  logic [31:0] dec_addr;
  logic [1:0]  dec_size;
  logic        remapped;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  addr_remap_dec u_addr_remap_dec (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [1:0]  rgn;
    logic [2:0]  cs;
    logic        ab;
    logic [31:0] oa;
  } vec_t;

  // Post-remap map: bank0 @0x800, bank1 and bank2 @0x010, bank3 @0x020 off, bank7 @0xFFB
  localparam vec_t VEC [0:12] = '{
    '{32'h0000_0000, 2'd2, 2'd1, 3'd0, 1'b0, 32'h0000_0000}, // R1
    '{32'h003F_FFFF, 2'd0, 2'd1, 3'd0, 1'b0, 32'h003F_FFFF}, // R1 edge
    '{32'h0040_0000, 2'd2, 2'd0, 3'd0, 1'b1, 32'h0040_0000}, // R6 no bank
    '{32'h0100_0002, 2'd1, 2'd2, 3'd1, 1'b0, 32'h0100_0002}, // R5 overlap, R8
    '{32'h0200_0000, 2'd2, 2'd0, 3'd0, 1'b1, 32'h0200_0000}, // R7 disabled
    '{32'h8001_2345, 2'd0, 2'd2, 3'd0, 1'b0, 32'h8001_2345}, // R5
    '{32'hFFB0_0010, 2'd2, 2'd2, 3'd7, 1'b0, 32'hFFB0_0010}, // R5
    '{32'hFFBF_FFFF, 2'd0, 2'd2, 3'd7, 1'b0, 32'hFFBF_FFFF}, // R5 edge
    '{32'hFFC0_0000, 2'd0, 2'd3, 3'd0, 1'b0, 32'hFFC0_0000}, // R4 edge
    '{32'hFFC0_0003, 2'd0, 2'd3, 3'd0, 1'b0, 32'hFFC0_0000}, // R4
    '{32'hFFFF_FFFE, 2'd1, 2'd3, 3'd0, 1'b0, 32'hFFFF_FFFC}, // R4
    '{32'hFFD1_2345, 2'd2, 2'd3, 3'd0, 1'b0, 32'hFFD1_2344}, // R4 undefined
    '{32'h0000_0020, 2'd1, 2'd1, 3'd0, 1'b0, 32'h0000_0020}  // R1 vectors
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz;
    #1;
  endtask

  task automatic remap_cmd(input logic b);
    @(negedge clk);
    remap_wr = 1'b1; remap_wbit = b;
    @(negedge clk);
    remap_wr = 1'b0; remap_wbit = 1'b0;
  endtask

  task automatic set_bank(input logic [2:0] i, input logic [11:0] b, input logic e);
    @(negedge clk);
    bank_wr = 1'b1; bank_idx = i; bank_base = b; bank_en = e;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    #1;
    chk("R10 remap clear", {31'd0, remapped}, 32'd0);
    chk("R9 idle region", {30'd0, dec_region}, 32'd0);
    chk("R9 idle abort", {31'd0, dec_abort}, 32'd0);

    // R2: boot device at zero even though bank 0 is disabled
    access(32'h0000_0010, 2'd2);
    chk("R2 boot region", {30'd0, dec_region}, 32'd2);
    chk("R2 boot cs", {29'd0, dec_cs}, 32'd0);
    chk("R2 boot abort", {31'd0, dec_abort}, 32'd0);

    set_bank(3'd0, 12'h800, 1'b1);
    set_bank(3'd1, 12'h010, 1'b1);
    set_bank(3'd2, 12'h010, 1'b1);
    set_bank(3'd3, 12'h020, 1'b0);
    set_bank(3'd7, 12'hFFB, 1'b1);

    // R6: bank 1 blocked before remap
    access(32'h0100_0004, 2'd2);
    chk("R6 gated abort", {31'd0, dec_abort}, 32'd1);
    chk("R6 gated region", {30'd0, dec_region}, 32'd0);
    access(32'h8000_0000, 2'd2);
    chk("R5 cs0 pre-remap", {29'd0, dec_cs, dec_region}, {27'd0, 3'd0, 2'd2});

    // R3: zero write has no effect
    remap_cmd(1'b0);
    #1;
    chk("R3 zero write", {31'd0, remapped}, 32'd0);
    access(32'h0000_0000, 2'd2);
    chk("R3 zero write map", {30'd0, dec_region}, 32'd2);
    remap_cmd(1'b1);
    #1;
    chk("R3 set", {31'd0, remapped}, 32'd1);

    for (int k = 0; k < 13; k++) begin
      access(VEC[k].a, VEC[k].sz);
      chk($sformatf("R1/R4/R5/R6/R7 vec%0d region", k), {30'd0, dec_region}, {30'd0, VEC[k].rgn});
      chk($sformatf("R5 vec%0d cs", k), {29'd0, dec_cs}, {29'd0, VEC[k].cs});
      chk($sformatf("R6 vec%0d abort", k), {31'd0, dec_abort}, {31'd0, VEC[k].ab});
      chk($sformatf("R8/R4 vec%0d addr", k), dec_addr, VEC[k].oa);
      chk($sformatf("R8/R4 vec%0d size", k), {30'd0, dec_size},
          {30'd0, (VEC[k].rgn == 2'd3) ? 2'd2 : VEC[k].sz});
    end

    // R9: external address without valid
    @(negedge clk);
    acc_valid = 1'b0; acc_addr = 32'h0040_0000;
    #1;
    chk("R9 invalid no abort", {29'd0, dec_abort, dec_region}, 32'd0);

    // R3: zero write after set keeps state
    remap_cmd(1'b0);
    #1;
    chk("R3 sticky", {31'd0, remapped}, 32'd1);

    // R10: reset restores boot map and disables banks
    do_reset();
    #1;
    chk("R10 remap after reset", {31'd0, remapped}, 32'd0);
    access(32'h0000_0000, 2'd2);
    chk("R10 boot map", {30'd0, dec_region}, 32'd2);
    remap_cmd(1'b1);
    access(32'h0100_0000, 2'd2);
    chk("R10 banks off", {31'd0, dec_abort}, 32'd1);
    access(32'hFFB0_0000, 2'd2);
    chk("R10 bank7 off", {31'd0, dec_abort}, 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule